// File: doc/BRIEF.md
# I3C Target Dynamic-Address Arbitration Responder

This block is the target-side part of an I3C device that has no address yet. It watches bus events that a separate decoder has already turned into single-cycle pulses: start, repeated start, stop, each received byte, and the rising and falling edges of SCL. From these it finds the broadcast commands that open and cancel an address-assignment round. It then takes part in the arbitration that follows a broadcast read header.

During arbitration the block sends a 64-bit identity made of the 48-bit provisional ID, the bus characteristics byte and the device characteristics byte. It only ever pulls SDA low or lets it go, so the bus acts as a wired-AND. If the block lets SDA go and then sees it low, it has lost that round and stays off the line until the next repeated start. If it wins, it takes in one address byte, acknowledges the byte when its parity is correct, and keeps the 7-bit address. The address stays valid until a reset-assignment broadcast clears it. After that the device answers private headers that carry its address.

Top module: `i3c_daa_target`

## Requirements
- R1: After reset, sda_pull, addr_valid and addr_hit are 0.
- R2: A broadcast read header (byte 0xFD, meaning address 0x7E with read) causes no bus activity unless an enter-assignment broadcast came before it in the same assignment mode and no address is held.
- R12: When the device is eligible, it acknowledges the 0xFD header by raising sda_pull from the first SCL fall after the header until the next SCL fall.
- R3: From that second fall on, the 64-bit identity {pid[47:0], bcr, dcr} is sent most-significant bit first, one bit per SCL fall. sda_pull is 1 for a 0 bit and 0 for a 1 bit.
- R4: If the device releases SDA and samples sda_in low on an SCL rise, it keeps sda_pull at 0 for the rest of that round.
- R5: A device that lost tries again on the next 0xFD header within the same assignment mode.
- R6: After a won round (the line is released on the fall that follows the last bit), the next received byte is {address[6:0], parity}. When the byte has odd parity, the device pulls SDA for one bit period from the next SCL fall, then sets addr_valid and stores dyn_addr.
- R7: On a parity error the device does not drive the acknowledge slot and stores no address.
- R8: While addr_valid is 1, enter-assignment commands and 0xFD headers are ignored, sda_pull stays 0, and dyn_addr does not change.
- R9: The broadcast command 0x06, sent as the byte after a 0xFC header (address 0x7E with write), clears addr_valid. The device can then take part in a later round that the command 0x07 opens.
- R10: A stop ends assignment mode and releases the line. A 0xFD header after a stop is ignored until 0x07 is received again.
- R11: One cycle after a header byte whose upper seven bits equal the stored valid address, addr_hit pulses high. It stays low for any other header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | Start condition seen (pulse) |
| ev_rstart | input | 1 | Repeated start seen (pulse) |
| ev_stop | input | 1 | Stop condition seen (pulse) |
| ev_byte | input | 1 | A full byte was received (pulse) |
| rx_byte | input | 8 | Received byte, valid with ev_byte |
| scl_rise | input | 1 | SCL rising edge (pulse) |
| scl_fall | input | 1 | SCL falling edge (pulse) |
| sda_in | input | 1 | Sampled SDA level |
| pid | input | 48 | Provisional ID |
| bcr | input | 8 | Bus characteristics byte |
| dcr | input | 8 | Device characteristics byte |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_valid | output | 1 | A dynamic address is held |
| dyn_addr | output | 7 | Stored dynamic address |
| addr_hit | output | 1 | Last header matched dyn_addr |

## Verification
The bench runs one arbitration round against a modelled rival whose identity differs from the device's at a single bit position, and it does this for all 64 positions. A shifter that sent bits in the wrong order, or one slot late, would pull SDA on the wrong SCL period. A device that did not withdraw would keep pulling after the bit where it lost. After every lost round the bench retries with no rival. It also injects address bytes with bad parity: a design with broken parity logic would acknowledge such a byte and keep a wrong address. Each iteration starts with a reset-assignment broadcast, so a sticky-address bug shows up in one of two ways. Either the device would fail to rejoin after 0x06, or it would drive the bus on 0xFD headers after it was assigned or after a stop.

// File: rtl/i3c_daa_pkg.sv
package i3c_daa_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam logic [BYTE_W-1:0] HDR_BCAST_WR = 8'hFC;
    localparam logic [BYTE_W-1:0] HDR_BCAST_RD = 8'hFD;
    localparam logic [BYTE_W-1:0] CMD_ENTER    = 8'h07;
    localparam logic [BYTE_W-1:0] CMD_CLEAR    = 8'h06;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HDR,
        PH_CCC,
        PH_DATA
    } frame_phase_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HACK,
        S_HACK_DRV,
        S_ARB,
        S_LOST,
        S_ARX,
        S_AACK,
        S_AACK_DRV
    } daa_state_t;

    typedef struct packed {
        logic       stb;
        logic [6:0] addr;
        logic       rnw;
    } header_t;

    function automatic logic parity_odd(input logic [BYTE_W-1:0] b);
        return ^b;
    endfunction

endpackage

// File: rtl/i3c_daa_cmd_decode.sv
module i3c_daa_cmd_decode
    import i3c_daa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_start,
    input  logic              ev_rstart,
    input  logic              ev_stop,
    input  logic              ev_byte,
    input  logic [BYTE_W-1:0] rx_byte,
    output header_t           hdr,
    output logic              data_stb,
    output logic              enter_cmd,
    output logic              clear_cmd
);

    frame_phase_t phase_q;
    logic         ccc_stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else if (ev_start || ev_rstart) begin
            phase_q <= PH_HDR;
        end else if (ev_stop) begin
            phase_q <= PH_IDLE;
        end else if (ev_byte) begin
            case (phase_q)
                PH_HDR:  phase_q <= (rx_byte == HDR_BCAST_WR) ? PH_CCC : PH_DATA;
                PH_CCC:  phase_q <= PH_DATA;
                default: phase_q <= phase_q;
            endcase
        end
    end

    always_comb begin
        hdr.stb   = ev_byte && (phase_q == PH_HDR);
        hdr.addr  = rx_byte[7:1];
        hdr.rnw   = rx_byte[0];
        ccc_stb   = ev_byte && (phase_q == PH_CCC);
        data_stb  = ev_byte && (phase_q == PH_DATA);
        enter_cmd = ccc_stb && (rx_byte == CMD_ENTER);
        clear_cmd = ccc_stb && (rx_byte == CMD_CLEAR);
    end

endmodule

// File: rtl/i3c_daa_id_shift.sv
module i3c_daa_id_shift #(
    parameter int unsigned ID_W = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            advance,
    input  logic [ID_W-1:0] id_word,
    output logic            cur_bit,
    output logic            last_bit
);

    localparam int unsigned CNT_W = $clog2(ID_W);

    logic [ID_W-1:0]  sh_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sh_q  <= id_word;
            cnt_q <= '0;
        end else if (advance) begin
            sh_q  <= {sh_q[ID_W-2:0], 1'b1};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cur_bit  = sh_q[ID_W-1];
    assign last_bit = (cnt_q == CNT_W'(ID_W - 1));

endmodule

// File: rtl/i3c_daa_target.sv
module i3c_daa_target
    import i3c_daa_pkg::*;
#(
    parameter int unsigned PID_W  = 48,
    parameter int unsigned CHAR_W = 8,
    parameter int unsigned ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_start,
    input  logic              ev_rstart,
    input  logic              ev_stop,
    input  logic              ev_byte,
    input  logic [7:0]        rx_byte,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_in,
    input  logic [PID_W-1:0]  pid,
    input  logic [CHAR_W-1:0] bcr,
    input  logic [CHAR_W-1:0] dcr,
    output logic              sda_pull,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] dyn_addr,
    output logic              addr_hit
);

    localparam int unsigned ID_W = PID_W + 2 * CHAR_W;

    header_t    hdr;
    logic       data_stb;
    logic       enter_cmd;
    logic       clear_cmd;
    daa_state_t st_q;
    logic       daa_mode_q;
    logic       ack_q;
    logic       hit_q;
    logic [7:0] rx_q;
    logic       cur_bit;
    logic       last_bit;
    logic       load_id;
    logic       adv_id;
    logic       arb_on;
    logic       bus_event;
    logic       join_round;

    i3c_daa_cmd_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .ev_start  (ev_start),
        .ev_rstart (ev_rstart),
        .ev_stop   (ev_stop),
        .ev_byte   (ev_byte),
        .rx_byte   (rx_byte),
        .hdr       (hdr),
        .data_stb  (data_stb),
        .enter_cmd (enter_cmd),
        .clear_cmd (clear_cmd)
    );

    i3c_daa_id_shift #(.ID_W(ID_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load_id),
        .advance  (adv_id),
        .id_word  ({pid, bcr, dcr}),
        .cur_bit  (cur_bit),
        .last_bit (last_bit)
    );

    assign arb_on     = (st_q == S_ARB);
    assign bus_event  = ev_start || ev_rstart || ev_stop;
    assign load_id    = (st_q == S_HACK_DRV) && scl_fall && !bus_event;
    assign adv_id     = arb_on && scl_fall && !last_bit && !bus_event;
    assign join_round = hdr.stb && ({hdr.addr, hdr.rnw} == HDR_BCAST_RD)
                        && daa_mode_q && !addr_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= S_IDLE;
            daa_mode_q <= 1'b0;
            ack_q      <= 1'b0;
            hit_q      <= 1'b0;
            rx_q       <= '0;
            addr_valid <= 1'b0;
            dyn_addr   <= '0;
        end else begin
            hit_q <= hdr.stb && addr_valid && (hdr.addr == dyn_addr);

            if (ev_stop) begin
                daa_mode_q <= 1'b0;
            end else if (enter_cmd && !addr_valid) begin
                daa_mode_q <= 1'b1;
            end

            if (clear_cmd) begin
                addr_valid <= 1'b0;
            end

            if (bus_event) begin
                st_q  <= S_IDLE;
                ack_q <= 1'b0;
            end else begin
                case (st_q)
                    S_IDLE: begin
                        if (join_round) st_q <= S_HACK;
                    end
                    S_HACK: begin
                        if (scl_fall) begin
                            ack_q <= 1'b1;
                            st_q  <= S_HACK_DRV;
                        end
                    end
                    S_HACK_DRV: begin
                        if (scl_fall) begin
                            ack_q <= 1'b0;
                            st_q  <= S_ARB;
                        end
                    end
                    S_ARB: begin
                        if (scl_rise && cur_bit && !sda_in) begin
                            st_q <= S_LOST;
                        end else if (scl_fall && last_bit) begin
                            st_q <= S_ARX;
                        end
                    end
                    S_LOST: begin
                        st_q <= S_LOST;
                    end
                    S_ARX: begin
                        if (data_stb) begin
                            rx_q <= rx_byte;
                            st_q <= S_AACK;
                        end
                    end
                    S_AACK: begin
                        if (scl_fall) begin
                            ack_q <= parity_odd(rx_q);
                            st_q  <= S_AACK_DRV;
                        end
                    end
                    S_AACK_DRV: begin
                        if (scl_fall) begin
                            ack_q <= 1'b0;
                            st_q  <= S_IDLE;
                            if (parity_odd(rx_q)) begin
                                addr_valid <= 1'b1;
                                dyn_addr   <= rx_q[7:1];
                            end
                        end
                    end
                    default: st_q <= S_IDLE;
                endcase
            end
        end
    end

    assign sda_pull = arb_on ? !cur_bit : ack_q;
    assign addr_hit = hit_q;

endmodule

module i3c_daa_target_chk #(
    parameter int unsigned ADDR_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              sda_pull,
    input logic              sda_in,
    input logic              scl_rise,
    input logic              ev_stop,
    input logic              addr_valid,
    input logic [ADDR_W-1:0] dyn_addr,
    input logic              addr_hit,
    input logic              clear_cmd,
    input logic              arb_on
);

    // R8
    no_drive_when_assigned_chk: assert property (@(posedge clk) disable iff (rst)
        sda_pull |-> !addr_valid);

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && $past(addr_valid)) |-> $stable(dyn_addr));

    // R9
    clear_drops_addr_chk: assert property (@(posedge clk) disable iff (rst)
        clear_cmd |=> !addr_valid);

    // R10
    stop_releases_chk: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> !sda_pull);

    // R6
    ack_precedes_valid_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_valid) |-> $past(sda_pull));

    // R4
    withdraw_on_loss_chk: assert property (@(posedge clk) disable iff (rst)
        (arb_on && !sda_pull && scl_rise && !sda_in) |=> !sda_pull);

    // R11
    hit_needs_addr_chk: assert property (@(posedge clk) disable iff (rst)
        addr_hit |-> addr_valid);

endmodule

bind i3c_daa_target i3c_daa_target_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sda_pull   (sda_pull),
    .sda_in     (sda_in),
    .scl_rise   (scl_rise),
    .ev_stop    (ev_stop),
    .addr_valid (addr_valid),
    .dyn_addr   (dyn_addr),
    .addr_hit   (addr_hit),
    .clear_cmd  (clear_cmd),
    .arb_on     (arb_on)
);

// File: tb/i3c_daa_target_bench.sv
module i3c_daa_target_bench;

    localparam logic [47:0] PID_V  = 48'h5A3C_9E17_42B1;
    localparam logic [7:0]  BCR_V  = 8'h66;
    localparam logic [7:0]  DCR_V  = 8'hC3;
    localparam logic [63:0] DUT_ID = {PID_V, BCR_V, DCR_V};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_start = 1'b0, ev_rstart = 1'b0, ev_stop = 1'b0, ev_byte = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       scl_rise = 1'b0, scl_fall = 1'b0, sda_in = 1'b1;
    logic       sda_pull, addr_valid, addr_hit;
    logic [6:0] dyn_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    i3c_daa_target u_i3c_daa_target (
        .clk(clk), .rst(rst), .ev_start(ev_start), .ev_rstart(ev_rstart),
        .ev_stop(ev_stop), .ev_byte(ev_byte), .rx_byte(rx_byte),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
        .pid(PID_V), .bcr(BCR_V), .dcr(DCR_V),
        .sda_pull(sda_pull), .addr_valid(addr_valid), .dyn_addr(dyn_addr),
        .addr_hit(addr_hit)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic p_start();  @(negedge clk) ev_start = 1;  @(negedge clk) ev_start = 0;  endtask
    task automatic p_rstart(); @(negedge clk) ev_rstart = 1; @(negedge clk) ev_rstart = 0; endtask
    task automatic p_stop();   @(negedge clk) ev_stop = 1;   @(negedge clk) ev_stop = 0;   endtask
    task automatic p_fall();   @(negedge clk) scl_fall = 1;  @(negedge clk) scl_fall = 0;  endtask
    task automatic p_rise();   @(negedge clk) scl_rise = 1;  @(negedge clk) scl_rise = 0;  endtask
    task automatic p_byte(input logic [7:0] b);
        @(negedge clk) begin ev_byte = 1; rx_byte = b; end
        @(negedge clk) ev_byte = 0;
    endtask

    function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic good);
        logic p;
        p = ~(^a);
        return {a, good ? p : ~p};
    endfunction

    // one arbitration round after a (repeated) start; returns whether the device won
    task automatic arb_round(input logic comp_on, input logic [63:0] comp_id, output logic won);
        logic lost_exp, comp_act, comp_low, line;
        lost_exp = 0;
        comp_act = comp_on;
        p_byte(8'hFD);
        p_fall();
        chk("R12 header ack", sda_pull, 1);
        p_fall();
        chk("R3 first bit", sda_pull, !DUT_ID[63]);
        for (int i = 63; i >= 0; i--) begin
            comp_low = comp_act && !comp_id[i];
            sda_in   = !(sda_pull || comp_low);
            line     = !((!lost_exp && !DUT_ID[i]) || comp_low);
            p_rise();
            if (!lost_exp && DUT_ID[i] && !line) lost_exp = 1;
            if (comp_act && comp_id[i] && !line) comp_act = 0;
            sda_in = 1;
            p_fall();
            if (i > 0)
                chk(lost_exp ? "R4 withdrawn" : "R3 bit", sda_pull, !lost_exp && !DUT_ID[i-1]);
            else
                chk("R6 release after last bit", sda_pull, 0);
        end
        won = !lost_exp;
    endtask

    task automatic give_addr(input logic [6:0] a, input logic good);
        p_byte(addr_byte(a, good));
        p_fall();
        chk(good ? "R6 ack slot" : "R7 nack slot", sda_pull, good);
        p_fall();
        chk("R6 ack released", sda_pull, 0);
        chk(good ? "R6 addr_valid" : "R7 no addr", addr_valid, good);
        if (good) chk("R6 dyn_addr", dyn_addr, a);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic won;
        logic [63:0] comp;
        logic [6:0] a;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        chk("R1 pull", sda_pull, 0);
        chk("R1 valid", addr_valid, 0);
        chk("R1 hit", addr_hit, 0);

        // R2: read header without enter command
        p_start(); p_byte(8'hFD); p_fall(); chk("R2 no ack", sda_pull, 0);
        p_fall(); chk("R2 silent", sda_pull, 0);
        p_stop();

        // R10: stop cancels assignment mode
        p_start(); p_byte(8'hFC); p_byte(8'h07); p_stop();
        p_start(); p_byte(8'hFD); p_fall(); chk("R10 ignored after stop", sda_pull, 0);
        p_fall(); chk("R10 silent", sda_pull, 0);
        p_stop();

        for (int k = 0; k < 64; k++) begin
            a = 7'(k + 8);
            comp = DUT_ID ^ (64'd1 << k);
            p_start(); p_byte(8'hFC); p_byte(8'h06);
            chk("R9 cleared", addr_valid, 0);
            p_rstart(); p_byte(8'hFC); p_byte(8'h07);
            p_rstart();
            arb_round(1'b1, comp, won);
            chk("R4 outcome", won, !DUT_ID[k]);
            if (!won) begin
                p_rstart();
                arb_round(1'b0, 64'd0, won);
                chk("R5 retry wins", won, 1);
            end
            if (k % 8 == 3) begin
                give_addr(a, 1'b0);
                p_rstart();
                arb_round(1'b0, 64'd0, won);
            end
            give_addr(a, 1'b1);
            // R8: further read header and enter command ignored
            p_rstart(); p_byte(8'hFD); p_fall();
            chk("R8 header ignored", sda_pull, 0);
            p_stop();
            p_start(); p_byte(8'hFC); p_byte(8'h07);
            p_rstart(); p_byte(8'hFD); p_fall();
            chk("R8 enter ignored", sda_pull, 0);
            chk("R8 addr kept", dyn_addr, a);
            p_stop();
            // R11
            p_start(); p_byte({a, 1'b0});
            chk("R11 hit", addr_hit, 1);
            p_rstart(); p_byte({a ^ 7'h01, 1'b1});
            chk("R11 miss", addr_hit, 0);
            p_stop();
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule